// File: doc/BRIEF.md
# Port Pin Change Detector

This block watches the upper pins of an 8-bit bidirectional port and tells the CPU when one of them has changed. It keeps a snapshot of those pins, taken each time software reads the port. While any watched pin that is set up as an input differs from its snapshot, a shared change flag is set. The flag is sticky. Software handles an event in two steps. First it reads the port, which refreshes the snapshot and removes the difference. Then it writes a flag clear.

Pins pass through a two-stage synchronizer before they are compared, and the port read returns the synchronized value. An interrupt request goes out when the change flag, a change-interrupt enable and a global interrupt enable are all set. Both enables come from one write strobe and are cleared by reset. When a watched pin is switched from output to input, its snapshot bit takes the pin's current value, so the switch is not reported as a change. Pin drivers and CPU vectoring are outside this block.

Top module: `pchg_detect_top`

## Requirements
- R1: After reset the change flag, both enables and the interrupt request are 0.
- R2: When a watched input pin (pins 7 to 4) changes away from its snapshot, the change flag reads 1 at the third rising clock edge after the change: two synchronizer stages plus the flag register. It still reads 0 after the second edge.
- R3: Pins 3 to 0 never set the change flag, whatever their values.
- R4: A watched pin whose direction bit is 0 (output) never sets the change flag. Direction bit k of `dir_i` belongs to pin k+4.
- R5: A one-cycle `port_rd_i` pulse copies the synchronized pins 7 to 4 into the snapshot. `port_data_o` shows the synchronized value of all 8 pins. After a read followed by a clear, the flag stays 0 while the pins hold still.
- R6: Once set, the change flag stays 1 until a `flag_clr_i` pulse, including after the port read. It reads 0 in the cycle after the clear.
- R7: If a mismatch is still present when the flag is cleared, the flag reads 0 for one cycle and then 1 again.
- R8: `irq_o` is 1 only when the change flag, the stored change enable and the stored global enable are all 1. The enables are loaded from `chg_en_i` and `glb_en_i` on a cycle with `en_we_i` high.
- R9: When a direction bit goes from 0 to 1, the snapshot bit takes the current synchronized pin value, so no change is flagged. Later changes on that pin are flagged as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 8 | Raw port pin levels |
| dir_i | input | 4 | Direction of pins 7..4, 1 = input |
| port_rd_i | input | 1 | Port read strobe; refreshes the snapshot |
| port_data_o | output | 8 | Synchronized pin levels returned by a port read |
| flag_clr_i | input | 1 | Software write that clears the change flag |
| en_we_i | input | 1 | Write strobe for the two enables |
| chg_en_i | input | 1 | Change-interrupt enable value to store |
| glb_en_i | input | 1 | Global interrupt enable value to store |
| chg_flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear that arrives while the mismatch is still present. It needs a pin change, a wait through the synchronizer, and then a clear issued without the port read that would normally come first. The bench builds this case on purpose and samples the flag in each of the two cycles after the clear, expecting 0 and then 1. A second case that is hard to reach is a direction switch made while the pin already differs from its stale snapshot. To set it up, the bench toggles a pin while it is configured as an output, then makes it an input, and checks that the flag stays 0.

// File: rtl/pchg_pkg.sv
package pchg_pkg;
  typedef struct packed {
    logic chg;
    logic glb;
  } pchg_en_t;
endpackage

// File: rtl/pchg_sync.sv
module pchg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pchg_snapshot.sv
module pchg_snapshot #(
  parameter int WATCH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WATCH_W-1:0] sync_i,
  input  logic [WATCH_W-1:0] dir_i,
  input  logic               rd_i,
  output logic               mismatch_o
);
  logic [WATCH_W-1:0] copy_q, copy_d;
  logic [WATCH_W-1:0] dir_q;
  logic [WATCH_W-1:0] load;

  always_comb begin
    load   = {WATCH_W{rd_i}} | (dir_i & ~dir_q);
    copy_d = (copy_q & ~load) | (sync_i & load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_q <= '0;
      dir_q  <= '0;
    end else begin
      copy_q <= copy_d;
      dir_q  <= dir_i;
    end
  end

  assign mismatch_o = |((sync_i ^ copy_q) & dir_q);

  a_r5_read_loads_copy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (copy_q == $past(sync_i)));

  generate
    for (genvar k = 0; k < WATCH_W; k++) begin : g_dirchk
      a_r9_dir_rise_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i[k] && !dir_q[k]) |=> (copy_q[k] == $past(sync_i[k])));
    end
  endgenerate
endmodule

// File: rtl/pchg_flag.sv
module pchg_flag
  import pchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic chg_en_i,
  input  logic glb_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic     flag_q, flag_d;
  pchg_en_t en_q, en_d;

  always_comb begin
    flag_d = clr_i ? 1'b0 : (flag_q | mismatch_i);
    en_d   = en_q;
    if (en_we_i) begin
      en_d.chg = chg_en_i;
      en_d.glb = glb_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_q.chg & en_q.glb;

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_q);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  a_r2_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(mismatch_i));
endmodule

// File: rtl/pchg_detect_top.sv
module pchg_detect_top #(
  parameter int PORT_W      = 8,
  parameter int WATCH_LO    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WATCH_W    = PORT_W - WATCH_LO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PORT_W-1:0]  pin_i,
  input  logic [WATCH_W-1:0] dir_i,
  input  logic               port_rd_i,
  output logic [PORT_W-1:0]  port_data_o,
  input  logic               flag_clr_i,
  input  logic               en_we_i,
  input  logic               chg_en_i,
  input  logic               glb_en_i,
  output logic               chg_flag_o,
  output logic               irq_o
);
  logic [1:0]        rst_q;
  logic              rst_n_s;
  logic [PORT_W-1:0] pin_sync;
  logic              mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  pchg_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  pchg_snapshot #(.WATCH_W(WATCH_W)) u_snap (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sync_i     (pin_sync[PORT_W-1:WATCH_LO]),
    .dir_i      (dir_i),
    .rd_i       (port_rd_i),
    .mismatch_o (mismatch)
  );

  pchg_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mismatch_i (mismatch),
    .clr_i      (flag_clr_i),
    .en_we_i    (en_we_i),
    .chg_en_i   (chg_en_i),
    .glb_en_i   (glb_en_i),
    .flag_o     (chg_flag_o),
    .irq_o      (irq_o)
  );

  assign port_data_o = pin_sync;

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> chg_flag_o);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_s) |-> (!chg_flag_o && !irq_o));
endmodule

// File: tb/pchg_detect_top_tb_top.sv
module pchg_detect_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_i;
  logic [3:0] dir_i;
  logic       port_rd_i, flag_clr_i, en_we_i, chg_en_i, glb_en_i;
  logic [7:0] port_data_o;
  logic       chg_flag_o, irq_o;
  int         n_chk = 0;
  int         n_fail = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  pchg_detect_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir_i(dir_i),
    .port_rd_i(port_rd_i), .port_data_o(port_data_o),
    .flag_clr_i(flag_clr_i), .en_we_i(en_we_i), .chg_en_i(chg_en_i),
    .glb_en_i(glb_en_i), .chg_flag_o(chg_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    port_rd_i = 1'b1; wait_n(1); port_rd_i = 1'b0;
  endtask

  task automatic do_clear();
    flag_clr_i = 1'b1; wait_n(1); flag_clr_i = 1'b0;
  endtask

  task automatic write_en(input bit c, input bit g);
    chg_en_i = c; glb_en_i = g; en_we_i = 1'b1; wait_n(1); en_we_i = 1'b0;
  endtask

  task automatic t_r1_reset();
    chk(chg_flag_o == 1'b0, "R1 flag", chg_flag_o, 0);
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    // enables are 0 after reset: raise the flag, irq must stay low
    pin_i[7] = 1'b1; wait_n(3);
    chk(irq_o == 1'b0, "R1 enables cleared", irq_o, 0);
    do_read(); do_clear(); wait_n(1);
  endtask

  task automatic t_r2_r5_detect();
    pin_i[5] = 1'b1;
    wait_n(2);
    chk(chg_flag_o == 1'b0, "R2 not before third edge", chg_flag_o, 0);
    wait_n(1);
    chk(chg_flag_o == 1'b1, "R2 set at third edge", chg_flag_o, 1);
    chk(port_data_o == pin_i, "R5 port data", port_data_o, pin_i);
    do_read();
    chk(chg_flag_o == 1'b1, "R6 held after read", chg_flag_o, 1);
    wait_n(4);
    chk(chg_flag_o == 1'b1, "R6 sticky", chg_flag_o, 1);
    do_clear();
    chk(chg_flag_o == 1'b0, "R6 cleared", chg_flag_o, 0);
    wait_n(5);
    chk(chg_flag_o == 1'b0, "R5 no mismatch after read", chg_flag_o, 0);
  endtask

  task automatic t_r7_reassert();
    pin_i[6] = 1'b1; wait_n(3);
    chk(chg_flag_o == 1'b1, "R7 pre set", chg_flag_o, 1);
    do_clear();
    chk(chg_flag_o == 1'b0, "R7 low one cycle", chg_flag_o, 0);
    wait_n(1);
    chk(chg_flag_o == 1'b1, "R7 sets again", chg_flag_o, 1);
    do_read(); do_clear(); wait_n(2);
    chk(chg_flag_o == 1'b0, "R5 settled", chg_flag_o, 0);
  endtask

  task automatic t_r3_low_pins();
    pin_i[3:0] = 4'hA; wait_n(4);
    pin_i[3:0] = 4'h5; wait_n(6);
    chk(chg_flag_o == 1'b0, "R3 low pins ignored", chg_flag_o, 0);
    chk(port_data_o == pin_i, "R5 port data low pins", port_data_o, pin_i);
  endtask

  task automatic t_r4_r9_direction();
    dir_i[0] = 1'b0; wait_n(1);
    pin_i[4] = 1'b1; wait_n(6);
    chk(chg_flag_o == 1'b0, "R4 output pin ignored", chg_flag_o, 0);
    dir_i[0] = 1'b1; wait_n(6);
    chk(chg_flag_o == 1'b0, "R9 no false flag on dir switch", chg_flag_o, 0);
    pin_i[4] = 1'b0; wait_n(3);
    chk(chg_flag_o == 1'b1, "R9 pin watched after switch", chg_flag_o, 1);
    do_read(); do_clear(); wait_n(1);
  endtask

  task automatic t_r8_irq();
    pin_i[7] = 1'b0; wait_n(3);
    chk(chg_flag_o == 1'b1, "R8 flag up", chg_flag_o, 1);
    chk(irq_o == 1'b0, "R8 no enables", irq_o, 0);
    write_en(1'b1, 1'b0);
    chk(irq_o == 1'b0, "R8 change enable only", irq_o, 0);
    write_en(1'b0, 1'b1);
    chk(irq_o == 1'b0, "R8 global enable only", irq_o, 0);
    write_en(1'b1, 1'b1);
    chk(irq_o == 1'b1, "R8 all set", irq_o, 1);
    do_read(); do_clear();
    chk(irq_o == 1'b0, "R8 irq drops with flag", irq_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; pin_i = 8'h00; dir_i = 4'hF;
    port_rd_i = 1'b0; flag_clr_i = 1'b0; en_we_i = 1'b0;
    chg_en_i = 1'b0; glb_en_i = 1'b0;
    wait_n(3); rst_n = 1'b1; wait_n(6);
    t_r1_reset();
    t_r2_r5_detect();
    t_r7_reassert();
    t_r3_low_pins();
    t_r4_r9_direction();
    t_r8_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule